// File: doc/BRIEF.md
# Headphone Playback Power Sequencer

This controller sits on the host side of an audio codec and brings the codec's headphone playback path up and down in a pop-free order. It walks a fixed list of register writes and hands each one, as an 8-bit address and 8-bit value, to an external serial-bus master through a request/acknowledge handshake. It holds timed pauses at three points: a PLL lock pause before the converter is powered, a rise pause while the amplifier common voltage settles, and a discharge pause before the amplifier supplies are removed.

A start command in the idle state arms the controller. The first write is not issued until the clock-ready flag confirms that the codec clocks are running. When the power-up list and the rise pause are complete, the controller sits in the playing state. A stop command then runs the power-down list. A stop that arrives during power-up is remembered and runs as soon as playing is reached. A start that arrives while the controller is busy or playing has no effect. Pause lengths are parameters in system-clock ticks.

States: `S_OFF` (idle), `S_ARM` (waiting for clocks), `S_WRITE` (request held), `S_HOLD` (timed pause), `S_STEP` (choose next step), `S_PLAY` (playing). Transitions: OFF→ARM on start; ARM→WRITE on clock-ready; WRITE→HOLD on acknowledge of a step that carries a pause; WRITE→STEP on acknowledge of a step without one; HOLD→STEP when the timer reaches zero; STEP→WRITE for the next step; STEP→PLAY after the last power-up step; STEP→OFF after the last power-down step; PLAY→WRITE (first power-down step) on a new or queued stop. An asynchronous reset returns the controller to OFF from any state.

Top module: `codec_play_seq`

## Requirements
- R1: After reset, busy, playing, done and wr_req are all low.
- R2: A start pulse in idle raises busy, and no write request is made while clk_ready is low.
- R3: Power-up issues exactly ten writes (address,data, hex) in this order: 05,27; 0F,09; 0E,19; 09,91; 0C,91; 0A,28; 0D,28; 00,64; 01,39; 01,79.
- R4: While wr_req is high and wr_ack is low, wr_req, wr_addr and wr_data hold their values. In the cycle after wr_ack is sampled high, wr_req is low.
- R5: The request for write 00,64 rises at least PLL_WAIT cycles after the acknowledge of write 0D,28.
- R6: playing rises at least RISE_WAIT cycles after the acknowledge of write 01,79. done pulses high for exactly one cycle as playing rises. busy and playing are never both high.
- R7: A stop pulse while playing issues exactly five writes in this order: 01,39; 01,09; 00,40; 0E,11; 0F,08.
- R8: The request for write 01,09 rises at least FALL_WAIT cycles after the acknowledge of the preceding 01,39 write.
- R9: When the power-down list completes, busy and playing are low and done pulses high for one cycle.
- R10: A stop pulse during power-up is held. Power-down starts within one cycle of reaching playing, with no further command.
- R11: A start while busy or playing, and a stop while idle, produce no write and leave the state unchanged.
- R12: Asserting rst_n low at any point forces the idle outputs at once, and no write follows after rst_n is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ready | input | 1 | Codec clocks confirmed running |
| start | input | 1 | Power-up command pulse |
| stop | input | 1 | Power-down command pulse |
| wr_ack | input | 1 | Bus master has taken the current write |
| wr_req | output | 1 | Write request, held until acknowledged |
| wr_addr | output | 8 | Codec register address of the current write |
| wr_data | output | 8 | Value of the current write |
| busy | output | 1 | Sequencing in progress |
| playing | output | 1 | Playback path fully up |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The bench compares the acknowledged write stream against the two expected lists, so a swapped or missing step shows up as an address or value mismatch. It measures the gaps at the PLL, rise and discharge pauses. A design that skips a pause, or starts it on the wrong step, produces a gap of only a few cycles and fails. It issues a stop in the middle of power-up, where a design that drops the queued stop would remain in playing. It also issues a start during playing and a stop in idle, where a design that honours them would issue extra writes. A slow acknowledge stresses the handshake, and a design that lets the request change or linger after acknowledge is caught. A mid-sequence asynchronous reset checks that the idle outputs appear before the next clock edge.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

    localparam int STEP_W = 4;

    typedef enum logic [1:0] {
        W_NONE,
        W_PLL,
        W_RISE,
        W_FALL
    } wait_kind_t;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
        wait_kind_t wk;
    } step_t;

    typedef enum logic [2:0] {
        S_OFF,
        S_ARM,
        S_WRITE,
        S_HOLD,
        S_STEP,
        S_PLAY
    } seq_state_t;

    // step indices: power-up list then power-down list
    localparam logic [STEP_W-1:0] UP_LAST  = 4'd9;
    localparam logic [STEP_W-1:0] DN_FIRST = 4'd10;
    localparam logic [STEP_W-1:0] DN_LAST  = 4'd14;

endpackage

// File: rtl/codec_step_rom.sv
module codec_step_rom
    import codec_seq_pkg::*;
(
    input  logic [STEP_W-1:0] idx,
    output step_t             step
);

    always_comb begin
        unique case (idx)
            4'd0:    step = '{addr: 8'h05, data: 8'h27, wk: W_NONE};
            4'd1:    step = '{addr: 8'h0F, data: 8'h09, wk: W_NONE};
            4'd2:    step = '{addr: 8'h0E, data: 8'h19, wk: W_NONE};
            4'd3:    step = '{addr: 8'h09, data: 8'h91, wk: W_NONE};
            4'd4:    step = '{addr: 8'h0C, data: 8'h91, wk: W_NONE};
            4'd5:    step = '{addr: 8'h0A, data: 8'h28, wk: W_NONE};
            4'd6:    step = '{addr: 8'h0D, data: 8'h28, wk: W_PLL};
            4'd7:    step = '{addr: 8'h00, data: 8'h64, wk: W_NONE};
            4'd8:    step = '{addr: 8'h01, data: 8'h39, wk: W_NONE};
            4'd9:    step = '{addr: 8'h01, data: 8'h79, wk: W_RISE};
            4'd10:   step = '{addr: 8'h01, data: 8'h39, wk: W_FALL};
            4'd11:   step = '{addr: 8'h01, data: 8'h09, wk: W_NONE};
            4'd12:   step = '{addr: 8'h00, data: 8'h40, wk: W_NONE};
            4'd13:   step = '{addr: 8'h0E, data: 8'h11, wk: W_NONE};
            4'd14:   step = '{addr: 8'h0F, data: 8'h08, wk: W_NONE};
            default: step = '{addr: 8'h00, data: 8'h00, wk: W_NONE};
        endcase
    end

endmodule

// File: rtl/codec_wait_timer.sv
module codec_wait_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             zero
);

    logic [WIDTH-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/codec_play_seq.sv
module codec_play_seq
    import codec_seq_pkg::*;
#(
    parameter int PLL_WAIT  = 500_000,
    parameter int RISE_WAIT = 12_500_000,
    parameter int FALL_WAIT = 25_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_ready,
    input  logic       start,
    input  logic       stop,
    input  logic       wr_ack,
    output logic       wr_req,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       busy,
    output logic       playing,
    output logic       done
);

    localparam int MAX_PR   = (PLL_WAIT > RISE_WAIT) ? PLL_WAIT : RISE_WAIT;
    localparam int MAX_WAIT = (MAX_PR > FALL_WAIT) ? MAX_PR : FALL_WAIT;
    localparam int CW       = $clog2(MAX_WAIT + 2);

    seq_state_t        state;
    logic [STEP_W-1:0] idx;
    logic              stop_pend;
    logic              done_q;
    step_t             cur;
    logic              tmr_load;
    logic              tmr_zero;
    logic [CW-1:0]     tmr_val;
    logic              in_powerup;

    codec_step_rom i_rom (
        .idx  (idx),
        .step (cur)
    );

    always_comb begin
        unique case (cur.wk)
            W_PLL:   tmr_val = CW'(PLL_WAIT);
            W_RISE:  tmr_val = CW'(RISE_WAIT);
            W_FALL:  tmr_val = CW'(FALL_WAIT);
            default: tmr_val = '0;
        endcase
    end

    assign tmr_load = (state == S_WRITE) && wr_ack && (cur.wk != W_NONE);

    codec_wait_timer #(.WIDTH(CW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign in_powerup = (state != S_OFF) && (state != S_PLAY) && (idx <= UP_LAST);

    // state register and transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_OFF;
            idx       <= '0;
            stop_pend <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (stop && in_powerup) begin
                stop_pend <= 1'b1;
            end
            unique case (state)
                S_OFF: begin
                    if (start) begin
                        idx   <= '0;
                        state <= S_ARM;
                    end
                end
                S_ARM: begin
                    if (clk_ready) begin
                        state <= S_WRITE;
                    end
                end
                S_WRITE: begin
                    if (wr_ack) begin
                        state <= (cur.wk == W_NONE) ? S_STEP : S_HOLD;
                    end
                end
                S_HOLD: begin
                    if (tmr_zero) begin
                        state <= S_STEP;
                    end
                end
                S_STEP: begin
                    if (idx == UP_LAST) begin
                        state  <= S_PLAY;
                        done_q <= 1'b1;
                    end else if (idx == DN_LAST) begin
                        state  <= S_OFF;
                        done_q <= 1'b1;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_WRITE;
                    end
                end
                S_PLAY: begin
                    if (stop || stop_pend) begin
                        stop_pend <= 1'b0;
                        idx       <= DN_FIRST;
                        state     <= S_WRITE;
                    end
                end
                default: state <= S_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_req  = (state == S_WRITE);
        wr_addr = wr_req ? cur.addr : 8'h00;
        wr_data = wr_req ? cur.data : 8'h00;
        busy    = (state == S_ARM) || (state == S_WRITE) ||
                  (state == S_HOLD) || (state == S_STEP);
        playing = (state == S_PLAY);
        done    = done_q;
    end

endmodule

// File: rtl/codec_play_seq_chk.sv
module codec_play_seq_chk #(
    parameter int PLL_WAIT  = 1,
    parameter int FALL_WAIT = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_ack,
    input logic       wr_req,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       busy,
    input logic       playing,
    input logic       done
);

    logic [31:0] since_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_ack <= '0;
        end else if (wr_req && wr_ack) begin
            since_ack <= '0;
        end else if (since_ack != 32'hFFFF_FFFF) begin
            since_ack <= since_ack + 1'b1;
        end
    end

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> !wr_req);

    assert_pll_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_req) && wr_addr == 8'h00 && wr_data == 8'h64)
            |-> (since_ack >= 32'(PLL_WAIT)));

    assert_fall_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_req) && wr_addr == 8'h01 && wr_data == 8'h09)
            |-> (since_ack >= 32'(FALL_WAIT)));

    assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && playing));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind codec_play_seq codec_play_seq_chk #(
    .PLL_WAIT  (PLL_WAIT),
    .FALL_WAIT (FALL_WAIT)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ack  (wr_ack),
    .wr_req  (wr_req),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .busy    (busy),
    .playing (playing),
    .done    (done)
);

// File: tb/test_codec_play_seq.sv
`timescale 1ns/1ps
module test_codec_play_seq;

    localparam int PLLW    = 20;
    localparam int RISEW   = 30;
    localparam int FALLW   = 40;
    localparam int ACK_LAT = 3;

    // expected write stream {addr,data}: 0..9 power-up, 10..14 power-down
    localparam logic [15:0] EXP [15] = '{
        16'h0527, 16'h0F09, 16'h0E19, 16'h0991, 16'h0C91,
        16'h0A28, 16'h0D28, 16'h0064, 16'h0139, 16'h0179,
        16'h0139, 16'h0109, 16'h0040, 16'h0E11, 16'h0F08
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_ready = 1'b0;
    logic start = 1'b0;
    logic stop = 1'b0;
    logic wr_ack = 1'b0;
    logic wr_req, busy, playing, done;
    logic [7:0] wr_addr, wr_data;

    always #4 clk = ~clk;

    codec_play_seq #(.PLL_WAIT(PLLW), .RISE_WAIT(RISEW), .FALL_WAIT(FALLW)) i_codec_play_seq (
        .clk(clk), .rst_n(rst_n), .clk_ready(clk_ready), .start(start), .stop(stop),
        .wr_ack(wr_ack), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .playing(playing), .done(done)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int lat = 0;
    int log_n = 0;
    int done_cnt = 0;
    int play_cnt = 0;
    int play_cyc = 0;
    int r4_bad = 0;
    bit prev_play = 1'b0;
    bit finished = 1'b0;
    logic [15:0] log_w [64];
    int log_c [64];

    // bus master model: acknowledges each request ACK_LAT cycles after it appears
    always @(negedge clk) begin
        cyc++;
        if (done) done_cnt++;
        if (playing && !prev_play) begin
            play_cnt++;
            play_cyc = cyc;
        end
        prev_play = playing;
        if (!rst_n) begin
            wr_ack = 1'b0;
            lat = 0;
        end else if (wr_ack) begin
            if (wr_req) r4_bad++;
            wr_ack = 1'b0;
        end else if (wr_req) begin
            lat++;
            if (lat == ACK_LAT) begin
                wr_ack = 1'b1;
                lat = 0;
                log_w[log_n] = {wr_addr, wr_data};
                log_c[log_n] = cyc;
                log_n++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        check(!busy && !playing && !done && !wr_req, "R1", "idle outputs",
              {busy, playing, done, wr_req}, 0);

        // R2 start waits for clock-ready
        pulse_start();
        cycles(20);
        check(busy == 1'b1, "R2", "busy after start", busy, 1);
        check(log_n == 0, "R2", "writes before clk_ready", log_n, 0);
        clk_ready = 1'b1;
        while (play_cnt < 1) @(negedge clk);
        cycles(1);

        // R3 power-up stream, walked from the table
        check(log_n == 10, "R3", "power-up write count", log_n, 10);
        for (int i = 0; i < 10; i++)
            check(log_w[i] == EXP[i], "R3", $sformatf("write %0d", i), log_w[i], EXP[i]);
        check(log_c[7] - log_c[6] >= PLLW, "R5", "PLL gap", log_c[7] - log_c[6], PLLW);
        check(play_cyc - log_c[9] >= RISEW, "R6", "rise gap", play_cyc - log_c[9], RISEW);
        check(done_cnt == 1, "R6", "done pulses after power-up", done_cnt, 1);

        // R11 start while playing ignored
        pulse_start();
        cycles(20);
        check(log_n == 10 && playing, "R11", "start while playing", log_n, 10);

        // R7 power-down
        pulse_stop();
        while (busy || playing) @(negedge clk);
        cycles(1);
        check(log_n == 15, "R7", "power-down write count", log_n, 15);
        for (int i = 10; i < 15; i++)
            check(log_w[i] == EXP[i], "R7", $sformatf("write %0d", i), log_w[i], EXP[i]);
        check(log_c[11] - log_c[10] >= FALLW, "R8", "fall gap", log_c[11] - log_c[10], FALLW);
        check(done_cnt == 2 && !busy && !playing, "R9", "completion", done_cnt, 2);

        // R11 stop while idle ignored
        pulse_stop();
        cycles(10);
        check(log_n == 15 && !busy, "R11", "stop while idle", log_n, 15);

        // R10 stop queued during power-up, start ignored while busy
        base = log_n;
        pulse_start();
        while (log_n < base + 3) @(negedge clk);
        pulse_stop();
        pulse_start();
        while (play_cnt < 2) @(negedge clk);
        while (busy || playing) @(negedge clk);
        cycles(1);
        check(log_n == base + 15, "R10", "queued run write count", log_n, base + 15);
        for (int i = 0; i < 15; i++)
            check(log_w[base + i] == EXP[i], "R10", $sformatf("queued write %0d", i),
                  log_w[base + i], EXP[i]);
        check(log_c[base + 10] - play_cyc <= ACK_LAT + 3, "R10", "prompt power-down",
              log_c[base + 10] - play_cyc, ACK_LAT + 3);
        check(done_cnt == 4, "R10", "done pulses", done_cnt, 4);

        // R4 request drops after each acknowledge
        check(r4_bad == 0, "R4", "request after ack", r4_bad, 0);

        // R12 asynchronous reset mid-sequence
        base = log_n;
        pulse_start();
        while (log_n < base + 4) @(negedge clk);
        #2 rst_n = 1'b0;
        #1 check(!busy && !wr_req && !playing, "R12", "async reset outputs",
                 {busy, wr_req, playing}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cycles(10);
        check(log_n == base + 4 && !busy, "R12", "no writes after reset", log_n, base + 4);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule